// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter assembled from identical narrow stages. Each stage holds a small count word. On every rising clock edge it does one of three things, chosen by a small operation decoder. OP_LOAD copies a parallel data word into the count. OP_COUNT adds one, and the count wraps from all-ones back to zero. OP_HOLD keeps the count as it is. An active-low clear input acts at once, with no clock edge, and forces every count bit to zero. It overrides every other input.

There are two count enables, and both must be high for a stage to count. The parallel enable goes to every stage unchanged. The carry enable is passed along the chain. Each stage drives a terminal-count flag, which is high when its carry enable is high and its count is all-ones. That flag feeds the carry enable of the next stage. The wrapper builds a counter STAGES times STAGE_W bits wide this way. Its final terminal-count output reports that the whole word is at all-ones and counting is enabled. A larger system can use that output to extend the chain.

The decoder picks an operation in a fixed order. OP_LOAD is taken whenever load is low. OP_COUNT is taken when load is high and both enables are high. OP_HOLD is taken in every other case. At each edge a stage moves from its present count to its next count by the chosen operation, unless clear is low.

Top module: `pcnt_chain`

## Requirements
- R1: The count changes only on a rising clock edge, or at once when clear goes low. A change on load, data or the enables between edges leaves the count word unchanged.
- R2: While clr_n is low, the count is zero and tc_out is low. This takes effect without a clock edge and whatever the levels on load, data and both enables.
- R3: When load_n is low at a rising edge, the count takes the value of din. This holds whatever the levels on en_par and en_carry.
- R4: When load_n is high and en_par and en_carry are both high at a rising edge, the count increments by one. The count wraps from all-ones to zero.
- R5: When load_n is high and either en_par or en_carry is low at a rising edge, the count keeps its value.
- R6: Terminal count is high exactly when en_carry is high and the count is all-ones. It follows en_carry between clock edges.
- R7: Stage k takes its carry enable from the terminal count of stage k-1, and stage 0 takes en_carry. Stage k occupies bits [k*STAGE_W +: STAGE_W]. The chain therefore counts as one binary counter of STAGES*STAGE_W bits, wrapping from all-ones to zero, and tc_out is the terminal count of the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | STAGES*STAGE_W | Parallel load data |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_carry | input | 1 | Carry count enable into stage 0 |
| q | output | STAGES*STAGE_W | Count word |
| tc_out | output | 1 | Terminal count of the last stage |

## Verification
Load and count can both be asked for at the same edge. The stimulus table drives load_n low with both enables high, and the bench expects din to appear with no increment. Clear can also meet a pending load or count. The bench pulls clr_n low partway through a clock period while load and both enables are active. It then checks that the count and tc_out are zero before the next edge and are still zero after that edge.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    // Per-edge operation of one counter stage
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } op_e;

endpackage

// File: rtl/pcnt_opdec.sv
module pcnt_opdec
    import pcnt_pkg::*;
(
    input  logic load_n,
    input  logic en_par,
    input  logic en_carry,
    output op_e  op
);

    // Load has priority over counting; counting needs both enables
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_carry) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
    import pcnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_par,
    input  logic         en_carry,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    op_e          op;
    logic [W-1:0] cnt_q;

    pcnt_opdec u_dec (
        .load_n   (load_n),
        .en_par   (en_par),
        .en_carry (en_carry),
        .op       (op)
    );

    // State register: asynchronous clear, otherwise one operation per edge
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  cnt_q <= din;
                OP_COUNT: cnt_q <= cnt_q + 1'b1;
                OP_HOLD:  cnt_q <= cnt_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // Outputs: count word and carry-gated terminal count
    always_comb begin
        q  = cnt_q;
        tc = en_carry && (&cnt_q);
    end

    // R3: load copies data regardless of the enables
    a_r3_load_copies: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R4: count with both enables, wrapping at the stage width
    a_r4_count_step: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_carry) |=> (q == W'($past(q) + 1'b1)));

    // R5: either enable low holds the count
    a_r5_hold_value: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_carry)) |=> $stable(q));

endmodule

// File: rtl/pcnt_chain.sv
module pcnt_chain #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 3
) (
    input  logic                         clk,
    input  logic                         clr_n,
    input  logic                         load_n,
    input  logic [STAGES*STAGE_W-1:0]    din,
    input  logic                         en_par,
    input  logic                         en_carry,
    output logic [STAGES*STAGE_W-1:0]    q,
    output logic                         tc_out
);

    localparam int TOTAL_W = STAGES * STAGE_W;

    // carry[k] is the carry enable into stage k
    logic [STAGES:0] carry;

    assign carry[0] = en_carry;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        pcnt_stage #(.W(STAGE_W)) u_stage (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .en_par   (en_par),
            .en_carry (carry[g]),
            .din      (din[g*STAGE_W +: STAGE_W]),
            .q        (q[g*STAGE_W +: STAGE_W]),
            .tc       (carry[g+1])
        );
    end

    assign tc_out = carry[STAGES];

    // R2: clear forces zero count and low terminal count
    a_r2_clear_zero: assert property (@(posedge clk)
        !clr_n |-> ((q == '0) && !tc_out));

    // R7: whole chain steps as one wide counter
    a_r7_chain_step: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_carry) |=> (q == TOTAL_W'($past(q) + 1'b1)));

    // R7: final terminal count only at full all-ones with carry enabled
    a_r7_chain_tc: assert property (@(posedge clk) disable iff (!clr_n)
        tc_out |-> (en_carry && (&q)));

endmodule

// File: tb/sim_pcnt_chain.sv
`timescale 1ns/1ps
module sim_pcnt_chain;

    localparam int SW = 4;
    localparam int NS = 3;
    localparam int TW = SW * NS;
    localparam logic [TW-1:0] ALL1 = '1;
    localparam int NVEC = 16;

    // Vector layout: {load_n, en_par, en_carry, din[11:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {3'b000, 12'hFFC},  // load while both enables low
        {3'b111, 12'h000},  // FFD
        {3'b111, 12'h000},  // FFE
        {3'b111, 12'h000},  // FFF
        {3'b110, 12'h123},  // hold, carry enable low
        {3'b101, 12'h456},  // hold, parallel enable low
        {3'b111, 12'h000},  // wrap to 000
        {3'b111, 12'h000},  // 001
        {3'b011, 12'h0FE},  // load and count requested together
        {3'b111, 12'h000},  // 0FF
        {3'b111, 12'h000},  // carry into third stage: 100
        {3'b000, 12'h00C},  // load twelve
        {3'b111, 12'h000},  // 00D
        {3'b111, 12'h000},  // 00E
        {3'b111, 12'h000},  // 00F
        {3'b111, 12'h000}   // 010
    };

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic          load_n = 1'b1;
    logic          en_par = 1'b0;
    logic          en_carry = 1'b0;
    logic [TW-1:0] din = '0;
    logic [TW-1:0] q;
    logic          tc_out;

    int checks = 0;
    int fails = 0;
    logic [TW-1:0] ref_q = '0;

    always #2.5 clk = ~clk;

    pcnt_chain #(.STAGE_W(SW), .STAGES(NS)) u0 (
        .clk      (clk),
        .clr_n    (clr_n),
        .load_n   (load_n),
        .din      (din),
        .en_par   (en_par),
        .en_carry (en_carry),
        .q        (q),
        .tc_out   (tc_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model of one rising edge
    task automatic model_edge();
        if (!load_n) ref_q = din;
        else if (en_par && en_carry) ref_q = ref_q + 1'b1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R2: clear acts before any clock edge
        #1 clr_n = 1'b0;
        #1;
        chk("R2", 32'(q), 32'h0);
        chk("R2", 32'(tc_out), 32'h0);
        // R2: clear overrides load and enables across an edge
        load_n = 1'b0; en_par = 1'b1; en_carry = 1'b1; din = 12'h5A5;
        @(posedge clk); #1;
        chk("R2", 32'(q), 32'h0);
        @(negedge clk);
        clr_n = 1'b1;
        ref_q = '0;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            {load_n, en_par, en_carry, din} = VEC[i];
            #1;
            chk("R6", 32'(tc_out), 32'(en_carry && (ref_q == ALL1)));
            chk("R1", 32'(q), 32'(ref_q));
            @(posedge clk);
            model_edge();
            @(negedge clk);
            if (!load_n)                 chk("R3", 32'(q), 32'(ref_q));
            else if (en_par && en_carry) chk("R4/R7", 32'(q), 32'(ref_q));
            else                         chk("R5", 32'(q), 32'(ref_q));
        end

        // R6: terminal count follows carry enable with no edge
        load_n = 1'b0; din = ALL1;
        @(posedge clk); @(negedge clk);
        load_n = 1'b1; en_par = 1'b0; en_carry = 1'b1;
        #0.5 chk("R6", 32'(tc_out), 32'h1);
        en_carry = 1'b0;
        #0.5 chk("R6", 32'(tc_out), 32'h0);
        en_carry = 1'b1;
        #0.5 chk("R6", 32'(tc_out), 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R5", 32'(q), 32'(ALL1));

        // R7: full three-stage wrap, final terminal count before the edge
        en_par = 1'b1;
        #0.5 chk("R7", 32'(tc_out), 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R7", 32'(q), 32'h0);
        chk("R7", 32'(tc_out), 32'h0);

        // R2: clear asserted partway through a period with load pending
        load_n = 1'b0; din = 12'hABC;
        #1 clr_n = 1'b0;
        #0.5;
        chk("R2", 32'(q), 32'h0);
        chk("R2", 32'(tc_out), 32'h0);
        @(posedge clk); #1;
        chk("R2", 32'(q), 32'h0);
        @(negedge clk);
        clr_n = 1'b1; load_n = 1'b1; en_par = 1'b1; en_carry = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R4", 32'(q), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule